// File: doc/BRIEF.md
# Two-Bank Interrupt Collector with Edge and Level Sources

This block gathers 64 interrupt inputs into two 32-bit banks and combines them into a single interrupt request line for one CPU. Each bank keeps four pieces of state:

- a sticky event register;
- an enable mask;
- a snapshot of the live input levels, taken every clock;
- a fixed per-bit trigger-type vector.

The trigger-type vector marks each source as either edge-latched or level-sensitive.

An edge-latched source sets its event bit while its input is high. The bit then stays set until software acknowledges it by writing a one to that bit of the clear register. A level-sensitive source never sets an event bit. It raises the request for exactly as long as its input stays high, and an acknowledge write does not affect it.

Software reaches the banks through a 32-bit register bus that decodes a 12-bit address. A request is a single-cycle strobe, and read data comes back one clock later. The request line is registered. It changes on the same clock edge as the state that causes it.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Input n (0..63) drives bank `1 - (n / 32)` at bit `n % 32`, so inputs 0..31 feed bank 1 and inputs 32..63 feed bank 0.
- R2: Each bank's level register holds the input values sampled at the previous clock edge. It reads at offset 0xC.
- R3: For a bit whose trigger type is edge, a high input sets the event bit. The event bit stays set after the input falls, until it is cleared. The event register reads at offset 0x0.
- R4: For a bit whose trigger type is level, the event bit is never set. The bit requests service only while its level bit and mask bit are both 1.
- R5: A write to offset 0x8 clears every edge-type event bit whose data bit is 1. It leaves level-type bits alone, and reading offset 0x8 returns 0.
- R6: When an edge-type input is high in the same cycle as a clear write to that bit, the event bit ends up set.
- R7: The mask reads and writes at offset 0x4. A bank requests service when `(events | (levels & trigtype)) & mask` is nonzero.
- R8: `irq_out` is the OR of both banks' requests. It updates on the same clock edge as the event, level or mask change that causes it.
- R9: The bank index is `(addr - 0x10) >> 4`, computed modulo 4096, so bank 0 sits at 0x10..0x1F and bank 1 at 0x20..0x2F. Writes to any other index, or to offsets other than 0x4 and 0x8, change nothing. Reads of them return 0.
- R10: Read data appears on `bus_rdata` one cycle after the read strobe. It shows the state from before that edge, and it is 0 in any cycle that follows no read.
- R11: After reset, every event, mask and level register is 0 and `irq_out` is low. The trigger-type vectors are 0x00000000 for bank 0 and 0x1FF00000 for bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Interrupt inputs, synchronous to clk |
| bus_valid | input | 1 | Single-cycle request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request to the CPU |

## Verification
Input latching and the software acknowledge can land on the same edge. An edge-type input can be high in exactly the cycle in which a clear write names its bit. The bench provokes this deliberately. It then reads the event register and expects the bit to remain set. A clear write to a held level-type source is also run, and the request is expected to stay high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int unsigned OFS_BITS = 4;

  typedef enum logic [OFS_BITS-1:0] {
    OFS_EVENT = 4'h0,
    OFS_MASK  = 4'h4,
    OFS_CLEAR = 4'h8,
    OFS_LEVEL = 4'hC
  } irqc_ofs_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BASE      = 16
) (
  input  logic                          valid,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  output logic [NUM_BANKS-1:0]          bank_sel,
  output logic [irqc_pkg::OFS_BITS-1:0] ofs,
  output logic                          is_wr,
  output logic                          is_rd
);
  localparam int unsigned IDX_W = ADDR_W - irqc_pkg::OFS_BITS;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;

  // subtraction wraps modulo the window, so addresses below BASE decode as huge indices
  assign rel   = addr - ADDR_W'(BASE);
  assign idx   = rel[ADDR_W-1:irqc_pkg::OFS_BITS];
  assign ofs   = addr[irqc_pkg::OFS_BITS-1:0];
  assign is_wr = valid & we;
  assign is_rd = valid & ~we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_sel[b] = valid && (idx == IDX_W'(b));
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned    W        = 32,
  parameter logic [W-1:0]   TRIG_LVL = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [W-1:0]                  src,
  input  logic                          sel,
  input  logic                          is_wr,
  input  logic [irqc_pkg::OFS_BITS-1:0] ofs,
  input  logic [W-1:0]                  wdata,
  output logic [W-1:0]                  ev_q,
  output logic [W-1:0]                  mk_q,
  output logic [W-1:0]                  lv_q,
  output logic                          req_next,
  output logic [W-1:0]                  rd_val
);
  import irqc_pkg::*;

  logic [W-1:0] clr_bits, ev_d, mk_d, lv_d;
  logic         wr_mask, wr_clr;

  assign wr_mask  = sel && is_wr && (ofs == OFS_MASK);
  assign wr_clr   = sel && is_wr && (ofs == OFS_CLEAR);
  assign clr_bits = wr_clr ? (wdata & ~TRIG_LVL) : '0;

  // a new edge event applied after the clear, so it wins a same-cycle collision
  assign ev_d = (ev_q & ~clr_bits) | (src & ~TRIG_LVL);
  assign lv_d = src;
  assign mk_d = wr_mask ? wdata : mk_q;

  assign req_next = |((ev_d | (lv_d & TRIG_LVL)) & mk_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      mk_q <= '0;
      lv_q <= '0;
    end else begin
      ev_q <= ev_d;
      mk_q <= mk_d;
      lv_q <= lv_d;
    end
  end

  always_comb begin
    unique case (ofs)
      OFS_EVENT: rd_val = ev_q;
      OFS_MASK:  rd_val = mk_q;
      OFS_LEVEL: rd_val = lv_q;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BASE      = 16,
  parameter logic [NUM_BANKS*BANK_W-1:0] TRIG_LVL = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*BANK_W-1:0]   irq_in,
  input  logic                          bus_valid,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  output logic                          irq_out
);
  localparam int unsigned OB = irqc_pkg::OFS_BITS;

  logic [NUM_BANKS-1:0]             bank_sel, bank_req;
  logic [OB-1:0]                    ofs;
  logic                             is_wr, is_rd;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_ev, bank_mk, bank_lv, bank_rd;
  logic [BANK_W-1:0]                rd_d;

  irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BASE(BASE)) u_dec (
    .valid(bus_valid), .we(bus_we), .addr(bus_addr),
    .bank_sel(bank_sel), .ofs(ofs), .is_wr(is_wr), .is_rd(is_rd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // highest input group feeds bank 0
    irqc_bank #(
      .W(BANK_W),
      .TRIG_LVL(TRIG_LVL[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk(clk), .rst(rst),
      .src(irq_in[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .sel(bank_sel[b]), .is_wr(is_wr), .ofs(ofs), .wdata(bus_wdata),
      .ev_q(bank_ev[b]), .mk_q(bank_mk[b]), .lv_q(bank_lv[b]),
      .req_next(bank_req[b]), .rd_val(bank_rd[b])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (is_rd && bank_sel[b]) rd_d = rd_d | bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      irq_out   <= |bank_req;
    end
  end
endmodule

// File: rtl/dual_bank_irq_ctrl_chk.sv
module dual_bank_irq_ctrl_chk #(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] TRIG_LVL = '0
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_BANKS*BANK_W-1:0]      irq_in,
  input logic                             bus_valid,
  input logic                             bus_we,
  input logic [BANK_W-1:0]                bus_rdata,
  input logic                             irq_out,
  input logic [NUM_BANKS-1:0][BANK_W-1:0] bank_ev,
  input logic [NUM_BANKS-1:0][BANK_W-1:0] bank_mk,
  input logic [NUM_BANKS-1:0][BANK_W-1:0] bank_lv
);
  logic [NUM_BANKS-1:0] req_now;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam logic [BANK_W-1:0] LT = TRIG_LVL[b*BANK_W +: BANK_W];
    assign req_now[b] = |((bank_ev[b] | (bank_lv[b] & LT)) & bank_mk[b]);

    // R2 with R1 mapping: level register follows the mapped input slice
    p_level_follows_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> bank_lv[b] == $past(irq_in[(NUM_BANKS-1-b)*BANK_W +: BANK_W]));

    // R3: without any write, event bits only accumulate
    p_event_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      !(bus_valid && bus_we) |=> (bank_ev[b] & $past(bank_ev[b])) == $past(bank_ev[b]));

    // R4: level-type bits never appear in the event register
    p_no_level_event_r4: assert property (@(posedge clk) disable iff (rst)
      (bank_ev[b] & LT) == '0);
  end

  // R8: registered request agrees with the bank state it was formed from
  p_irq_matches_r8: assert property (@(posedge clk) disable iff (rst)
    irq_out == |req_now);

  // R10: read data bus is zero when no read was issued
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_we) |=> bus_rdata == '0);
endmodule

bind dual_bank_irq_ctrl dual_bank_irq_ctrl_chk #(
  .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .TRIG_LVL(TRIG_LVL)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .irq_out(irq_out),
  .bank_ev(bank_ev), .bank_mk(bank_mk), .bank_lv(bank_lv)
);

// File: tb/dual_bank_irq_ctrl_bench.sv
module dual_bank_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0, fails = 0;
  logic [31:0] m_ev [2];
  logic [31:0] m_mk [2];
  logic [31:0] m_lv [2];
  logic [31:0] m_lt [2];
  logic [31:0] exp_rd;
  logic        exp_irq;

  always #2.5 clk = ~clk;

  dual_bank_irq_ctrl u_dual_bank_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0;
    end
    m_lt[0] = 32'h0000_0000;
    m_lt[1] = 32'h1FF0_0000;
  endtask

  // one bus/input cycle; checks rdata and irq_out after the edge
  task automatic cycle(string tag, logic [63:0] in, logic v, logic we,
                       logic [11:0] a, logic [31:0] d);
    logic [11:0] rel;
    int bk;
    logic [3:0] of;
    logic [31:0] src, clr, irq_v;
    @(negedge clk);
    irq_in = in; bus_valid = v; bus_we = we; bus_addr = a; bus_wdata = d;
    rel = a - 12'h010;
    bk  = int'(rel[11:4]);
    of  = a[3:0];
    exp_rd = '0;
    if (v && !we && bk < 2) begin
      case (of)
        4'h0: exp_rd = m_ev[bk];
        4'h4: exp_rd = m_mk[bk];
        4'hC: exp_rd = m_lv[bk];
        default: exp_rd = '0;
      endcase
    end
    irq_v = '0;
    for (int b = 0; b < 2; b++) begin
      src = (b == 0) ? in[63:32] : in[31:0];
      clr = (v && we && bk == b && of == 4'h8) ? (d & ~m_lt[b]) : '0;
      m_ev[b] = (m_ev[b] & ~clr) | (src & ~m_lt[b]);
      m_lv[b] = src;
      if (v && we && bk == b && of == 4'h4) m_mk[b] = d;
      irq_v[b] = |((m_ev[b] | (m_lv[b] & m_lt[b])) & m_mk[b]);
    end
    exp_irq = |irq_v;
    @(posedge clk);
    #1;
    check({tag, " rdata"}, bus_rdata, exp_rd);
    check({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, exp_irq});
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [63:0] in);
    cycle(tag, in, 1'b1, 1'b0, a, '0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R11 reset irq_out", {31'b0, irq_out}, 32'h0);
    check("R11 reset rdata", bus_rdata, 32'h0);
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 16; o += 4)
        rd("R11 reset readback", 12'(16 + 16*b + o), '0);

    // mask writes and readback
    cycle("R7 mask wr b0", '0, 1, 1, 12'h014, 32'hFFFF_FFFF);
    cycle("R7 mask wr b1", '0, 1, 1, 12'h024, 32'hFFFF_FFFF);
    rd("R7 mask rd b0", 12'h014, '0);
    rd("R7 mask rd b1", 12'h024, '0);

    // sweep every input: pulse, then read events and levels, then acknowledge
    for (int n = 0; n < 64; n++) begin
      automatic logic [11:0] base = (n < 32) ? 12'h020 : 12'h010;
      automatic logic [63:0] one = 64'd1 << n;
      cycle("R1 pulse", one, 0, 0, '0, '0);
      rd("R2 level while high", base + 12'hC, one);
      cycle("R3 drop", '0, 0, 0, '0, '0);
      rd("R3 R4 event after drop", base, '0);
      rd("R5 clear reads zero", base + 12'h8, '0);
      cycle("R5 ack", '0, 1, 1, base + 12'h8, 32'd1 << (n % 32));
      rd("R5 event after ack", base, '0);
    end

    // same-cycle set and clear on an edge bit (input 37 -> bank 0 bit 5)
    cycle("R6 prime", 64'd1 << 37, 0, 0, '0, '0);
    cycle("R6 collide", 64'd1 << 37, 1, 1, 12'h018, 32'h20);
    cycle("R6 release", '0, 0, 0, '0, '0);
    rd("R6 event survives", 12'h010, '0);
    cycle("R6 ack", '0, 1, 1, 12'h018, 32'hFFFF_FFFF);

    // held level source (input 24 -> bank 1 bit 24) is immune to ack
    cycle("R4 hold", 64'd1 << 24, 0, 0, '0, '0);
    cycle("R5 ack level", 64'd1 << 24, 1, 1, 12'h028, 32'hFFFF_FFFF);
    cycle("R4 still high", 64'd1 << 24, 0, 0, '0, '0);
    cycle("R8 level drop", '0, 0, 0, '0, '0);

    // masking: both banks pending, mask off one bank at a time
    cycle("R8 two events", (64'd1 << 3) | (64'd1 << 40), 0, 0, '0, '0);
    cycle("R7 mask b0 off", '0, 1, 1, 12'h014, 32'h0);
    cycle("R7 mask b1 off", '0, 1, 1, 12'h024, 32'h0);
    cycle("R7 mask b1 on", '0, 1, 1, 12'h024, 32'h8);

    // addresses outside the banks or at unused offsets
    cycle("R9 wr low", '0, 1, 1, 12'h004, 32'h1234);
    cycle("R9 wr high", '0, 1, 1, 12'h034, 32'h1234);
    cycle("R9 wr far", '0, 1, 1, 12'hF14, 32'h1234);
    cycle("R9 wr ofs5", '0, 1, 1, 12'h015, 32'h1234);
    cycle("R9 wr ofs0", '0, 1, 1, 12'h020, 32'h0);
    rd("R9 mask b0 kept", 12'h014, '0);
    rd("R9 mask b1 kept", 12'h024, '0);
    rd("R9 rd invalid", 12'h034, '0);
    rd("R9 rd low", 12'h00C, '0);
    rd("R9 rd ofs1", 12'h021, '0);
    rd("R3 event b1 kept", 12'h020, '0);

    // idle cycle after a read returns zero
    cycle("R10 idle", '0, 0, 0, 12'h020, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule